// File: doc/BRIEF.md
# Reciprocal Refinement Residual Unit

This unit computes the correction term used in one Newton-Raphson step of a reciprocal: given a reduced-precision seed `x` for `1/b` and the original value `b`, it returns `r = 1.0 - x*b` as a single-precision number. A following multiply-add `x + x*r` then roughly doubles the number of correct bits of the seed. The product is kept exact, the constant is subtracted, and one round-to-nearest-even step produces the result, so the residual behaves like a fused operation even when `x*b` is very close to one.

Inputs and outputs are 64-bit words. In single mode only the low 32 bits carry an operand. In paired mode each 32-bit half is a separate lane, and both lanes get the same operation. Denormal inputs are read as zero and the output is never denormal. The pipeline is three registers deep and accepts one operation per cycle under a valid/ready handshake. When the consumer holds back, the whole pipeline stalls.

Flag vector encoding: bit 4 invalid, bit 3 unimplemented format, bit 2 overflow, bit 1 underflow, bit 0 inexact.

Top module: `rrr_unit`

## Requirements
- R1: For finite operands the result equals 1.0 - x*b computed exactly and then rounded once to nearest-even in single precision.
- R2: An input with exponent field 0 is used as a zero of the same sign, whatever its fraction bits.
- R3: No result lane is ever denormal. A result whose exponent would fall at or below zero becomes a zero of the result's sign, with flag bits 1 and 0 set.
- R4: A result that is exactly zero is returned as +0.0 (0x00000000) with no flags.
- R5: If either lane operand is a NaN, or one is infinite and the other is zero after R2, the lane result is 0x7FC00000 and flag bit 4 is set.
- R6: Infinity times a nonzero finite value gives an infinity whose sign is opposite to the product's sign, with no flags.
- R7: A finite result too large for single precision becomes an infinity of the result's sign, with flag bits 2 and 0 set.
- R8: Flag bit 0 is set exactly when rounding discarded nonzero bits.
- R9: With format code 1 (paired), bits 63:32 and 31:0 are separate lanes, and the flag output is the OR of both lanes' flags.
- R10: With format code 0 (single), only bits 31:0 are used. Result bits 63:32 are zero, and the upper operand halves affect neither result nor flags.
- R11: Format codes 2 and 3 give an all-zero result with only flag bit 3 set.
- R12: An operation accepted on a clock edge appears on the output three edges later when nothing stalls. A new operation may be accepted every cycle while `in_ready` is high. The output is held while `out_valid` is high and `out_ready` is low. After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_fmt | input | 2 | 0 single, 1 paired, 2/3 unimplemented |
| in_seed | input | 64 | Seed x, one or two single lanes |
| in_orig | input | 64 | Original value b, one or two single lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Residual 1.0 - x*b per lane |
| out_flags | output | 5 | Exception flags, encoding above |

## Verification
Assertions check on every cycle that no output lane is denormal or negative zero, that a default NaN always carries the invalid flag, that an overflow flag comes with an infinite lane, and that a stalled output stays unchanged. The numeric value of the residual, its rounding and inexact flag, denormal-input flushing, lane independence, the format codes and the three-cycle latency can only be shown by the bench. It sweeps seeds near 1/b in paired mode and random operand pairs in single mode, and checks each result against a real-number model with random backpressure.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  localparam int SW   = 32;
  localparam int EW   = 8;
  localparam int MW   = 23;
  localparam int BIAS = 127;
  localparam int PW   = 2 * (MW + 1);
  localparam int GRD  = 3;
  localparam int MAGW = PW + GRD + 2;
  localparam int XW   = 11;
  localparam int LW   = $clog2(MAGW);
  localparam int ONE_POS = PW - 2 + GRD;

  localparam logic [1:0] FMT_SGL  = 2'd0;
  localparam logic [1:0] FMT_PAIR = 2'd1;
  localparam logic [SW-1:0] QNAN  = 32'h7FC0_0000;

  typedef struct packed {
    logic invalid;
    logic unimpl;
    logic overflow;
    logic underflow;
    logic inexact;
  } flags_t;

  typedef struct packed {
    logic                 special;
    logic [SW-1:0]        sval;
    flags_t               sflags;
    logic                 psign;
    logic signed [XW-1:0] pexp;
    logic [PW-1:0]        prod;
  } front_t;

  typedef struct packed {
    logic                 special;
    logic [SW-1:0]        sval;
    flags_t               sflags;
    logic                 sign;
    logic signed [XW-1:0] fexp;
    logic [MAGW-1:0]      mag;
  } mid_t;
endpackage

// File: rtl/rrr_front.sv
module rrr_front
  import rrr_pkg::*;
(
  input  logic [SW-1:0] seed_i,
  input  logic [SW-1:0] orig_i,
  output front_t        fr_o
);
  logic [EW-1:0] ea, eb;
  logic [MW-1:0] fa, fb;
  logic za, zb, ia, ib, na, nb;
  logic [MW:0] ma, mb;

  always_comb begin
    ea = seed_i[SW-2 -: EW];
    eb = orig_i[SW-2 -: EW];
    fa = seed_i[MW-1:0];
    fb = orig_i[MW-1:0];
    // exponent field zero: zero or denormal, both read as zero
    za = (ea == '0);
    zb = (eb == '0);
    ia = (ea == '1) && (fa == '0);
    ib = (eb == '1) && (fb == '0);
    na = (ea == '1) && (fa != '0);
    nb = (eb == '1) && (fb != '0);
    ma = za ? '0 : {1'b1, fa};
    mb = zb ? '0 : {1'b1, fb};

    fr_o       = '0;
    fr_o.psign = seed_i[SW-1] ^ orig_i[SW-1];
    fr_o.prod  = PW'(ma) * PW'(mb);
    fr_o.pexp  = (za || zb) ? '0 : (XW'(ea) + XW'(eb) - XW'(2 * BIAS));
    if (na || nb || (ia && zb) || (ib && za)) begin
      fr_o.special        = 1'b1;
      fr_o.sval           = QNAN;
      fr_o.sflags.invalid = 1'b1;
    end else if (ia || ib) begin
      fr_o.special = 1'b1;
      fr_o.sval    = {~fr_o.psign, {EW{1'b1}}, {MW{1'b0}}};
    end
  end
endmodule

// File: rtl/rrr_align.sv
module rrr_align
  import rrr_pkg::*;
(
  input  front_t fr_i,
  output mid_t   md_o
);
  localparam logic [MAGW-1:0] ONE_AL = MAGW'(1) << ONE_POS;

  function automatic logic [MAGW-1:0] shr_jam(input logic [MAGW-1:0] v,
                                              input logic [XW-1:0] sh);
    logic [MAGW-1:0] r;
    logic [MAGW-1:0] lost;
    if (sh >= XW'(MAGW)) return {{(MAGW-1){1'b0}}, |v};
    r    = v >> sh;
    lost = ~({MAGW{1'b1}} << sh);
    r[0] = r[0] | (|(v & lost));
    return r;
  endfunction

  logic [XW-1:0]   shp;
  logic [MAGW-1:0] x1, xp;
  logic [MAGW:0]   diff;

  always_comb begin
    md_o         = '0;
    md_o.special = fr_i.special;
    md_o.sval    = fr_i.sval;
    md_o.sflags  = fr_i.sflags;
    // common frame: exponent of the larger of 1.0 and the product
    md_o.fexp    = (fr_i.pexp > 0) ? fr_i.pexp : '0;
    shp          = md_o.fexp - fr_i.pexp;
    x1           = shr_jam(ONE_AL, md_o.fexp);
    xp           = shr_jam({2'b00, fr_i.prod, {GRD{1'b0}}}, shp);
    diff         = {1'b0, x1} - {1'b0, xp};
    if (fr_i.psign) begin
      md_o.mag  = x1 + xp;
      md_o.sign = 1'b0;
    end else if (diff[MAGW]) begin
      md_o.mag  = '0 - diff[MAGW-1:0];
      md_o.sign = 1'b1;
    end else begin
      md_o.mag  = diff[MAGW-1:0];
      md_o.sign = 1'b0;
    end
  end
endmodule

// File: rtl/rrr_round.sv
module rrr_round
  import rrr_pkg::*;
(
  input  mid_t          md_i,
  output logic [SW-1:0] res_o,
  output flags_t        flg_o
);
  logic [LW-1:0]   lead;
  logic [MAGW-1:0] norm;
  logic [MW:0]     mant;
  logic [MW+1:0]   mant_r;
  logic            g, st, up;
  logic [XW-1:0]   ex;
  logic [MW-1:0]   frac;

  always_comb begin
    lead = '0;
    for (int k = 0; k < MAGW; k++) begin
      if (md_i.mag[k]) lead = LW'(k);
    end
    norm   = md_i.mag << (LW'(MAGW - 1) - lead);
    mant   = norm[MAGW-1 -: MW+1];
    g      = norm[MAGW-MW-2];
    st     = |norm[MAGW-MW-3:0];
    up     = g & (st | mant[0]);
    mant_r = {1'b0, mant} + (MW+2)'(up);
    ex     = XW'(lead) + md_i.fexp - XW'(ONE_POS) + XW'(BIAS);
    frac   = mant_r[MW-1:0];
    if (mant_r[MW+1]) begin
      ex   = ex + XW'(1);
      frac = '0;
    end

    res_o = '0;
    flg_o = '0;
    if (md_i.special) begin
      res_o = md_i.sval;
      flg_o = md_i.sflags;
    end else if (md_i.mag == '0) begin
      res_o = '0;
    end else if ($signed(ex) >= $signed(XW'(2 * BIAS + 1))) begin
      res_o          = {md_i.sign, {EW{1'b1}}, {MW{1'b0}}};
      flg_o.overflow = 1'b1;
      flg_o.inexact  = 1'b1;
    end else if ($signed(ex) <= 0) begin
      res_o           = {md_i.sign, {(SW-1){1'b0}}};
      flg_o.underflow = 1'b1;
      flg_o.inexact   = 1'b1;
    end else begin
      res_o         = {md_i.sign, ex[EW-1:0], frac};
      flg_o.inexact = g | st;
    end
  end
endmodule

// File: rtl/rrr_unit.sv
module rrr_unit
  import rrr_pkg::*;
#(
  parameter  int LANES = 2,
  localparam int DW    = SW * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_fmt,
  input  logic [DW-1:0] in_seed,
  input  logic [DW-1:0] in_orig,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [4:0]    out_flags
);
  logic       adv;
  logic       v1, v2, v3;
  logic [1:0] fmt1, fmt2;
  logic       unimpl_q;

  front_t fr_c [LANES];
  front_t fr_q [LANES];
  mid_t   md_c [LANES];
  mid_t   md_q [LANES];
  logic [SW-1:0] res_c [LANES];
  flags_t        flg_c [LANES];
  logic [SW-1:0] res_q [LANES];
  flags_t        flg_q [LANES];

  assign adv       = !v3 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      fmt1 <= FMT_SGL; fmt2 <= FMT_SGL; unimpl_q <= 1'b0;
    end else if (adv) begin
      v1       <= in_valid;
      v2       <= v1;
      v3       <= v2;
      fmt1     <= in_fmt;
      fmt2     <= fmt1;
      unimpl_q <= (fmt2 != FMT_SGL) && (fmt2 != FMT_PAIR);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic active;
    assign active = (fmt2 == FMT_PAIR) || ((i == 0) && (fmt2 == FMT_SGL));

    rrr_front u_front (.seed_i(in_seed[SW*i +: SW]), .orig_i(in_orig[SW*i +: SW]), .fr_o(fr_c[i]));
    rrr_align u_align (.fr_i(fr_q[i]), .md_o(md_c[i]));
    rrr_round u_round (.md_i(md_q[i]), .res_o(res_c[i]), .flg_o(flg_c[i]));

    always_ff @(posedge clk) begin
      if (rst) begin
        fr_q[i]  <= '0;
        md_q[i]  <= '0;
        res_q[i] <= '0;
        flg_q[i] <= '0;
      end else if (adv) begin
        fr_q[i]  <= fr_c[i];
        md_q[i]  <= md_c[i];
        res_q[i] <= active ? res_c[i] : '0;
        flg_q[i] <= active ? flg_c[i] : '0;
      end
    end

    assign out_result[SW*i +: SW] = res_q[i];

    // R3: no denormal lane ever leaves the unit
    a_r3_no_denorm: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !((out_result[SW*i+MW +: EW] == '0) && (out_result[SW*i +: MW] != '0)));
    // R4: zero results are positive
    a_r4_pos_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_result[SW*i +: SW] != 32'h8000_0000));
    // R5: default NaN is always reported as invalid
    a_r5_nan_flag: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_result[SW*i +: SW] == QNAN) |-> out_flags[4]);
    // R7: a lane that reports overflow carries an infinity
    a_r7_ovf_inf: assert property (@(posedge clk) disable iff (rst)
      (out_valid && flg_q[i].overflow) |->
        (out_result[SW*i+MW +: EW] == '1) && (out_result[SW*i +: MW] == '0));
  end

  always_comb begin
    out_flags = {1'b0, unimpl_q, 3'b000};
    for (int k = 0; k < LANES; k++) out_flags = out_flags | flg_q[k];
  end

  // R12: a stalled result stays put
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));
endmodule

// File: tb/rrr_unit_tb_top.sv
module rrr_unit_tb_top;
  localparam int NMAX = 6000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = 2'd0;
  logic [63:0] in_seed = '0;
  logic [63:0] in_orig = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [4:0]  out_flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]  st_fmt [NMAX];
  logic [63:0] st_x   [NMAX];
  logic [63:0] st_b   [NMAX];
  logic [68:0] st_exp [NMAX];
  string       st_tag [NMAX];
  int          n_items = 0;

  always #4 clk = ~clk;

  rrr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_seed(in_seed), .in_orig(in_orig),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  function automatic real val(input logic [31:0] w);
    real m, p;
    int  e;
    e = int'(w[30:23]);
    if (e == 0) return 0.0;
    m = 1.0 + real'(w[22:0]) / 8388608.0;
    p = 1.0;
    if (e > 127) repeat (e - 127) p = p * 2.0;
    else repeat (127 - e) p = p / 2.0;
    return w[31] ? -(m * p) : m * p;
  endfunction

  // single rounding of an exact real to single precision: {flags, bits}
  function automatic logic [36:0] to_single(input real r);
    real    m, sc, ip, fr;
    int     e;
    longint mi;
    logic   s;
    logic [4:0] f;
    if (r == 0.0) return '0;
    s = (r < 0.0);
    m = s ? -r : r;
    e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    e  = e + 127;
    sc = m * 8388608.0;
    ip = $floor(sc);
    fr = sc - ip;
    mi = longint'(ip);
    f  = (fr != 0.0) ? 5'b00001 : 5'b00000;
    if (fr > 0.5 || (fr == 0.5 && mi[0])) mi++;
    if (mi == 64'd16777216) begin mi = 64'd8388608; e++; end
    if (e >= 255) return {5'b00101, s, 8'hFF, 23'd0};
    if (e <= 0) return {5'b00011, s, 31'd0};
    return {f, s, 8'(e), mi[22:0]};
  endfunction

  function automatic logic [36:0] lane_model(input logic [31:0] x, input logic [31:0] b);
    logic zx, zb, ix, ib, nx, nb, ps;
    zx = (x[30:23] == 8'h00); zb = (b[30:23] == 8'h00);
    ix = (x[30:23] == 8'hFF) && (x[22:0] == 0); ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    nx = (x[30:23] == 8'hFF) && (x[22:0] != 0); nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ps = x[31] ^ b[31];
    if (nx || nb || (ix && zb) || (ib && zx)) return {5'b10000, 32'h7FC0_0000};
    if (ix || ib) return {5'b00000, ~ps, 8'hFF, 23'd0};
    return to_single(1.0 - val(x) * val(b));
  endfunction

  task automatic add(input logic [1:0] f, input logic [63:0] x, input logic [63:0] b, input string tag);
    logic [36:0] lo, hi;
    lo = lane_model(x[31:0], b[31:0]);
    hi = lane_model(x[63:32], b[63:32]);
    st_fmt[n_items] = f; st_x[n_items] = x; st_b[n_items] = b; st_tag[n_items] = tag;
    if (f == 2'd1)      st_exp[n_items] = {hi[36:32] | lo[36:32], hi[31:0], lo[31:0]};
    else if (f == 2'd0) st_exp[n_items] = {lo[36:32], 32'd0, lo[31:0]};
    else                st_exp[n_items] = {5'b01000, 64'd0};
    n_items++;
  endtask

  task automatic check(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_for(input logic [31:0] b);
    logic [36:0] t;
    t = to_single(1.0 / val(b));
    return {t[31:8], 8'h00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog: actual=hung expected=drained");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wr, rd, cnt, notready;
    logic [31:0] b0, b1, xr, br;
    void'($urandom(7));

    // directed cases
    add(2'd0, {32'hFFFF_FFFF, 32'h3F80_0000}, {32'h7FC0_1234, 32'h3F80_0000}, "R4 R10 one-times-one");
    add(2'd0, 64'h4000_0000, 64'h4040_0000, "R1 two-times-three");
    add(2'd0, 64'h0001_2345, 64'h4040_0000, "R2 denormal seed");
    add(2'd0, 64'h40A0_0000, 64'h807F_FFFF, "R2 denormal orig");
    add(2'd0, 64'h7F80_0000, 64'h0000_0001, "R2 R5 inf times denormal");
    add(2'd0, 64'h3F80_0000, 64'h7FA0_0000, "R5 NaN operand");
    add(2'd0, 64'h7F80_0000, 64'h4000_0000, "R6 +inf times 2");
    add(2'd0, 64'hFF80_0000, 64'h4000_0000, "R6 -inf times 2");
    add(2'd0, 64'h7F7F_FFFF, 64'hFF7F_FFFF, "R7 overflow");
    add(2'd0, 64'h3F80_0001, 64'h4B80_0000, "R8 tie to even");
    add(2'd0, 64'h3EAA_AAAB, 64'h4040_0000, "R1 R8 third");
    add(2'd1, {32'h7FC0_0001, 32'h4000_0000}, {32'h3F80_0000, 32'h4040_0000}, "R9 NaN upper lane");
    add(2'd1, {32'h4000_0000, 32'h7F80_0000}, {32'h4040_0000, 32'h0000_0000}, "R9 invalid lower lane");
    add(2'd2, 64'h4000_0000, 64'h4040_0000, "R11 format 2");
    add(2'd3, 64'h7FC0_0000, 64'h7FC0_0000, "R11 format 3");
    // seed refinement sweep, paired
    for (int i = 0; i < 2048; i++) begin
      b0 = {i[0], 8'(127 + (i % 9) - 4), i[10:0], 12'(i * 37 + 5)};
      b1 = {i[1], 8'(127 - (i % 7) + 3), 12'(i * 13 + 1), i[10:0]};
      add(2'd1, {seed_for(b1), seed_for(b0)}, {b1, b0}, "R1 R9 seed sweep");
    end
    // random operand pairs with moderate exponents, single
    for (int i = 0; i < 2000; i++) begin
      xr = {1'($urandom), 8'(124 + $urandom % 7), 23'($urandom)};
      br = {1'($urandom), 8'(124 + $urandom % 7), 23'($urandom)};
      add(2'd0, {$urandom, xr}, {$urandom, br}, "R1 R8 R10 random");
    end

    // reset state, R12
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R12 reset state", {67'd0, out_valid, in_ready}, 69'd1);
    rst = 1'b0;

    wr = 0; rd = 0; notready = 0;
    while (rd < n_items) begin
      @(negedge clk);
      out_ready = (rd < n_items / 2) ? 1'b1 : ($urandom % 4 != 0);
      if (wr < n_items) begin
        in_valid = 1'b1; in_fmt = st_fmt[wr]; in_seed = st_x[wr]; in_orig = st_b[wr];
      end else in_valid = 1'b0;
      #1;
      if (out_valid && out_ready) begin
        check({out_flags, out_result} === st_exp[rd], st_tag[rd], {out_flags, out_result}, st_exp[rd]);
        for (int l = 0; l < 2; l++)  // R3 no denormal lane
          check(!(out_result[32*l+23 +: 8] == 0 && out_result[32*l +: 23] != 0), "R3 denormal output",
                {37'd0, out_result[32*l +: 32]}, 69'd0);
        rd++;
      end
      if (rd < n_items / 2 && wr < n_items && !in_ready) notready++;
      if (in_valid && in_ready) wr++;
    end
    check(notready == 0, "R12 one per cycle", 69'(notready), 69'd0);

    // latency, R12
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_fmt = 2'd0;
    in_seed = 64'h4000_0000; in_orig = 64'h4040_0000;
    cnt = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      cnt++;
      #1;
    end while (!out_valid && cnt < 10);
    check(cnt == 3, "R12 latency", 69'(cnt), 69'd3);
    check(out_result == 64'hC0A0_0000, "R12 R1 latency result", {5'd0, out_result}, {5'd0, 64'hC0A0_0000});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule